// File: doc/BRIEF.md
# NAND-Style Flash Command Sequencer

This block is the device-side command and operation controller for an 8-bit multiplexed NAND-style flash interface. Byte events reach it already qualified: a command strobe, an address strobe or a data strobe, each valid for one clock with the byte on `din`. A read strobe advances the output byte. The block decodes command codes and tracks multi-cycle sequences. It checks that the two-step setup/confirm operations are complete. It raises one-clock start pulses for page load, page program and block erase, and holds an active-low ready/busy line for a parameterised number of cycles.

Software reads a status byte through the same output port. That byte reports the outcome of the last program or erase, the ready state and the write-protect state. The block also returns a three-byte identification sequence and handles reset. A reset aborts whatever is running and then holds the device busy for a short, parameterised recovery time.

The cell array and column pointer arithmetic belong to neighbouring logic. In page-data mode this block drives 00h.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `rb_n` is 1, `dout` is 00h and all three start pulses are 0.
- R2: A command byte outside the set {00h, 01h, 50h, 90h, FFh, 80h, 10h, 60h, D0h, 70h} changes nothing: sequence state and `dout` stay as they were.
- R3: A read command (00h, 01h or 50h) followed by three address bytes pulses `load_start` and drives `rb_n` low for `T_READ` cycles, both starting the clock after the third address. With fewer address bytes no load starts. After a load, `dout` reads 00h.
- R4: The sequence 80h, three address bytes, at least one data byte and then 10h pulses `prog_start` and holds `rb_n` low for `T_PROG` cycles, starting the clock after 10h. A 10h with no data byte since the address phase starts nothing.
- R5: The sequence 60h, two address bytes and then D0h pulses `erase_start` and holds `rb_n` low for `T_ERASE` cycles, starting the clock after D0h.
- R6: While `wp_n` is 0, a program or erase confirm starts nothing and `rb_n` stays 1.
- R7: While busy, only 70h and FFh take effect. All other commands, and all address and data bytes, are ignored.
- R8: Status byte: bit 0 is the fail flag (1 = fail), bit 6 is 1 when ready, bit 7 equals `wp_n`, and bits 1 to 5 are 0.
- R9: After 70h, `dout` shows the live status byte on every read strobe until the next accepted command.
- R10: The fail flag takes the inverse of `op_pass`, sampled in the last busy cycle of a program or erase. Read loads leave it unchanged.
- R11: The sequence 90h then address byte 00h makes `dout` return ECh, then `DEV_CODE`, then A5h, advancing by one on each read strobe, and 00h after that. Any other address byte gives 00h.
- R12: FFh aborts the running operation and clears the sequence, the output mode and the fail flag, so status reads C0h with `wp_n` high. `rb_n` is low for `T_RST_IDLE` cycles when FFh arrives while ready, and for `T_RST_BUSY` cycles when it aborts a busy operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte event on `din` |
| addr_we | input | 1 | Address byte event on `din` |
| data_we | input | 1 | Data byte event on `din` |
| rd_stb | input | 1 | Read strobe, advances the output byte |
| din | input | 8 | Command, address or data byte |
| wp_n | input | 1 | Write protect, active low |
| op_pass | input | 1 | Pass/fail result of the array operation (1 = pass) |
| rb_n | output | 1 | Ready (1) / busy (0) |
| dout | output | 8 | Output byte: status, ID or 00h |
| prog_start | output | 1 | One-clock page program start |
| erase_start | output | 1 | One-clock block erase start |
| load_start | output | 1 | One-clock page load start |

## Verification
A wrong sequence state shows up only at the confirm byte. That is when a start pulse is missing or spurious and `rb_n` fails to fall one clock later. The bench therefore checks every start pulse in the cycle right after the confirm and measures the exact busy length. A stale fail flag or output mode hides until the next 70h. For that reason each operation ends with a status read, compared against a model of the fail flag kept in the bench. Commands sent while busy, and undefined codes, are checked by reading the status byte afterwards: it must still be on `dout`, which shows that the output mode was not disturbed.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    CK_BAD, CK_READ, CK_ID, CK_RESET, CK_PSETUP,
    CK_PCONF, CK_ESETUP, CK_ECONF, CK_STATUS
  } cmd_kind_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RD_ADDR, PH_PG_ADDR, PH_PG_NODATA,
    PH_PG_DATA, PH_ER_ADDR, PH_ER_CONF, PH_ID_ADDR
  } phase_t;

  typedef enum logic [1:0] {OM_NONE, OM_STATUS, OM_ID, OM_DATA} out_mode_t;

  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE, OP_RST} op_kind_t;

  localparam logic [7:0] C_RD_LO   = 8'h00;
  localparam logic [7:0] C_RD_HI   = 8'h01;
  localparam logic [7:0] C_RD_SP   = 8'h50;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_RESET   = 8'hFF;
  localparam logic [7:0] C_PG_SET  = 8'h80;
  localparam logic [7:0] C_PG_GO   = 8'h10;
  localparam logic [7:0] C_ER_SET  = 8'h60;
  localparam logic [7:0] C_ER_GO   = 8'hD0;
  localparam logic [7:0] C_STAT    = 8'h70;

  localparam logic [7:0] MAKER_BYTE = 8'hEC;
  localparam logic [7:0] TAIL_BYTE  = 8'hA5;

  function automatic cmd_kind_t classify(input logic [7:0] code);
    case (code)
      C_RD_LO, C_RD_HI, C_RD_SP: return CK_READ;
      C_IDENT:  return CK_ID;
      C_RESET:  return CK_RESET;
      C_PG_SET: return CK_PSETUP;
      C_PG_GO:  return CK_PCONF;
      C_ER_SET: return CK_ESETUP;
      C_ER_GO:  return CK_ECONF;
      C_STAT:   return CK_STATUS;
      default:  return CK_BAD;
    endcase
  endfunction

  function automatic logic allowed_while_busy(input cmd_kind_t k);
    return (k == CK_STATUS) || (k == CK_RESET);
  endfunction

  function automatic logic [7:0] status_byte(input logic fail, input logic ready,
                                             input logic wp_ok);
    return {wp_ok, ready, 5'b00000, fail};
  endfunction

  function automatic logic [7:0] id_byte(input logic [1:0] idx, input logic [7:0] dev);
    case (idx)
      2'd0:    return MAKER_BYTE;
      2'd1:    return dev;
      2'd2:    return TAIL_BYTE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
(
  input  logic [7:0] code,
  output cmd_kind_t  kind,
  output logic       busy_ok
);
  always_comb begin
    kind    = classify(code);
    busy_ok = allowed_while_busy(kind);
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CW'(1)) && !load;
endmodule

// File: rtl/flash_out_sel.sv
module flash_out_sel
  import flash_seq_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h75
) (
  input  out_mode_t  mode,
  input  logic [1:0] idx,
  input  logic [7:0] stat,
  output logic [7:0] dout
);
  always_comb begin
    case (mode)
      OM_STATUS: dout = stat;
      OM_ID:     dout = id_byte(idx, DEV_CODE);
      default:   dout = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int         T_READ     = 20,
  parameter int         T_PROG     = 40,
  parameter int         T_ERASE    = 60,
  parameter int         T_RST_IDLE = 5,
  parameter int         T_RST_BUSY = 12,
  parameter int         COL_CYCLES = 1,
  parameter int         ROW_CYCLES = 2,
  parameter logic [7:0] DEV_CODE   = 8'h75
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       addr_we,
  input  logic       data_we,
  input  logic       rd_stb,
  input  logic [7:0] din,
  input  logic       wp_n,
  input  logic       op_pass,
  output logic       rb_n,
  output logic [7:0] dout,
  output logic       prog_start,
  output logic       erase_start,
  output logic       load_start
);
  localparam int T_MAX    = max2(max2(max2(T_READ, T_PROG), max2(T_ERASE, T_RST_IDLE)), T_RST_BUSY);
  localparam int CW       = $clog2(T_MAX + 1);
  localparam int TOT_ADDR = COL_CYCLES + ROW_CYCLES;
  localparam int ACW      = $clog2(TOT_ADDR + 1);

  function automatic int cycles_needed(input phase_t ph);
    case (ph)
      PH_RD_ADDR, PH_PG_ADDR: return TOT_ADDR;
      PH_ER_ADDR:             return ROW_CYCLES;
      default:                return 1;
    endcase
  endfunction

  cmd_kind_t     ck;
  logic          busy_ok;
  logic          busy, t_last, t_load;
  logic [CW-1:0] t_val;

  phase_t        phase_q, phase_d;
  out_mode_t     mode_q, mode_d;
  op_kind_t      op_q, op_d;
  logic [ACW-1:0] acnt_q, acnt_d;
  logic [1:0]    idx_q, idx_d;
  logic          fail_q, fail_d;
  logic          ps_q, ps_d, es_q, es_d, ls_q, ls_d;

  // named events for the checker
  logic ev_busy_reject;
  logic cmd_ok, addr_ok, data_ok, rd_ok, addr_last;

  flash_cmd_decode u_dec (
    .code    (din),
    .kind    (ck),
    .busy_ok (busy_ok)
  );

  flash_busy_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .busy     (busy),
    .last     (t_last)
  );

  assign cmd_ok         = cmd_we && (!busy || busy_ok);
  assign ev_busy_reject = cmd_we && busy && !busy_ok;
  assign addr_ok        = addr_we && !cmd_we && !busy;
  assign data_ok        = data_we && !cmd_we && !addr_we && !busy;
  assign rd_ok          = rd_stb && !cmd_we && !addr_we && !data_we;
  assign addr_last      = (int'(acnt_q) == cycles_needed(phase_q) - 1);

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    op_d    = op_q;
    acnt_d  = acnt_q;
    idx_d   = idx_q;
    fail_d  = fail_q;
    ps_d    = 1'b0;
    es_d    = 1'b0;
    ls_d    = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;

    if (t_last) begin
      if (op_q == OP_PROG || op_q == OP_ERASE) fail_d = ~op_pass;
      op_d = OP_NONE;
    end

    if (cmd_ok) begin
      case (ck)
        CK_RESET: begin
          phase_d = PH_IDLE;
          mode_d  = OM_NONE;
          fail_d  = 1'b0;
          op_d    = OP_RST;
          t_load  = 1'b1;
          t_val   = busy ? CW'(T_RST_BUSY) : CW'(T_RST_IDLE);
        end
        CK_STATUS: mode_d = OM_STATUS;
        CK_READ: begin
          phase_d = PH_RD_ADDR;
          acnt_d  = '0;
          mode_d  = OM_NONE;
        end
        CK_ID: begin
          phase_d = PH_ID_ADDR;
          mode_d  = OM_NONE;
        end
        CK_PSETUP: begin
          phase_d = PH_PG_ADDR;
          acnt_d  = '0;
          mode_d  = OM_NONE;
        end
        CK_ESETUP: begin
          phase_d = PH_ER_ADDR;
          acnt_d  = '0;
          mode_d  = OM_NONE;
        end
        CK_PCONF: begin
          if (phase_q == PH_PG_DATA && wp_n) begin
            ps_d   = 1'b1;
            op_d   = OP_PROG;
            t_load = 1'b1;
            t_val  = CW'(T_PROG);
          end
          phase_d = PH_IDLE;
          mode_d  = OM_NONE;
        end
        CK_ECONF: begin
          if (phase_q == PH_ER_CONF && wp_n) begin
            es_d   = 1'b1;
            op_d   = OP_ERASE;
            t_load = 1'b1;
            t_val  = CW'(T_ERASE);
          end
          phase_d = PH_IDLE;
          mode_d  = OM_NONE;
        end
        default: ;
      endcase
    end else if (addr_ok) begin
      case (phase_q)
        PH_RD_ADDR: begin
          if (addr_last) begin
            ls_d    = 1'b1;
            op_d    = OP_READ;
            t_load  = 1'b1;
            t_val   = CW'(T_READ);
            mode_d  = OM_DATA;
            phase_d = PH_IDLE;
          end else acnt_d = acnt_q + 1'b1;
        end
        PH_PG_ADDR: begin
          if (addr_last) phase_d = PH_PG_NODATA;
          else           acnt_d  = acnt_q + 1'b1;
        end
        PH_ER_ADDR: begin
          if (addr_last) phase_d = PH_ER_CONF;
          else           acnt_d  = acnt_q + 1'b1;
        end
        PH_ID_ADDR: begin
          if (din == 8'h00) begin
            mode_d = OM_ID;
            idx_d  = 2'd0;
          end
          phase_d = PH_IDLE;
        end
        default: ;
      endcase
    end else if (data_ok) begin
      if (phase_q == PH_PG_NODATA) phase_d = PH_PG_DATA;
    end else if (rd_ok) begin
      if (mode_q == OM_ID && idx_q != 2'd3) idx_d = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mode_q  <= OM_NONE;
      op_q    <= OP_NONE;
      acnt_q  <= '0;
      idx_q   <= 2'd0;
      fail_q  <= 1'b0;
      ps_q    <= 1'b0;
      es_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
      op_q    <= op_d;
      acnt_q  <= acnt_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      ps_q    <= ps_d;
      es_q    <= es_d;
      ls_q    <= ls_d;
    end
  end

  flash_out_sel #(.DEV_CODE(DEV_CODE)) u_out (
    .mode (mode_q),
    .idx  (idx_q),
    .stat (status_byte(fail_q, ~busy, wp_n)),
    .dout (dout)
  );

  assign rb_n        = ~busy;
  assign prog_start  = ps_q;
  assign erase_start = es_q;
  assign load_start  = ls_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [7:0] din,
  input logic       wp_n,
  input logic       rb_n,
  input logic [7:0] dout,
  input logic       prog_start,
  input logic       erase_start,
  input logic       load_start,
  input logic       ev_busy_reject,
  input phase_t     phase_q,
  input out_mode_t  mode_q
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start, load_start})); // R3

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start || load_start) |-> !rb_n); // R4

  AST_ERASE_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(cmd_we && din == 8'hD0)); // R5

  AST_PROG_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(cmd_we && din == 8'h10 && phase_q == PH_PG_DATA)); // R4

  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> $past(wp_n)); // R6

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy_reject |=> ($stable(phase_q) && $stable(mode_q))); // R7

  AST_STATUS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OM_STATUS) |-> (dout[5:1] == 5'd0 && dout[6] == rb_n && dout[7] == wp_n)); // R8

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OM_STATUS && !cmd_we) |=> (mode_q == OM_STATUS)); // R9
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_we         (cmd_we),
  .din            (din),
  .wp_n           (wp_n),
  .rb_n           (rb_n),
  .dout           (dout),
  .prog_start     (prog_start),
  .erase_start    (erase_start),
  .load_start     (load_start),
  .ev_busy_reject (ev_busy_reject),
  .phase_q        (phase_q),
  .mode_q         (mode_q)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int TR  = 20;
  localparam int TP  = 40;
  localparam int TE  = 60;
  localparam int TRI = 5;
  localparam int TRB = 12;
  localparam logic [7:0] DEV = 8'h75;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, addr_we = 0, data_we = 0, rd_stb = 0;
  logic [7:0] din = 8'h00;
  logic wp_n = 1, op_pass = 1;
  logic rb_n, prog_start, erase_start, load_start;
  logic [7:0] dout;

  int n_chk = 0, n_bad = 0;
  logic fail_m = 0;
  logic finished = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.T_READ(TR), .T_PROG(TP), .T_ERASE(TE), .T_RST_IDLE(TRI),
                  .T_RST_BUSY(TRB), .DEV_CODE(DEV)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .addr_we(addr_we), .data_we(data_we),
    .rd_stb(rd_stb), .din(din), .wp_n(wp_n), .op_pass(op_pass), .rb_n(rb_n),
    .dout(dout), .prog_start(prog_start), .erase_start(erase_start), .load_start(load_start)
  );

  function automatic logic [7:0] exp_status(input logic f, input logic rdy, input logic wp);
    logic [7:0] s;
    s = 8'h00;
    s[0] = f; s[6] = rdy; s[7] = wp;
    return s;
  endfunction

  function automatic logic is_defined(input logic [7:0] b);
    return b inside {8'h00, 8'h01, 8'h50, 8'h90, 8'hFF, 8'h80, 8'h10, 8'h60, 8'hD0, 8'h70};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_cmd(input logic [7:0] b);
    @(negedge clk); din = b; cmd_we = 1;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic put_addr(input logic [7:0] b);
    @(negedge clk); din = b; addr_we = 1;
    @(negedge clk); addr_we = 0;
  endtask
  task automatic put_data(input logic [7:0] b);
    @(negedge clk); din = b; data_we = 1;
    @(negedge clk); data_we = 0;
  endtask
  task automatic strobe();
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
  endtask
  task automatic busy_len(output int n);
    n = 0;
    while (rb_n == 1'b0 && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic do_program(input logic wp, input logic pass, input int ndata);
    int n;
    logic go;
    wp_n = wp; op_pass = pass;
    put_cmd(8'h80);
    for (int i = 0; i < 3; i++) put_addr(8'($urandom));
    for (int i = 0; i < ndata; i++) put_data(8'($urandom));
    put_cmd(8'h10);
    go = wp && (ndata > 0);
    chk("R4/R6 prog_start", 32'(prog_start), 32'(go));
    if (go) begin
      busy_len(n);
      chk("R4 program busy length", 32'(n), 32'(TP));
      fail_m = !pass;
    end else chk("R4/R6 stays ready", 32'(rb_n), 32'd1);
    put_cmd(8'h70);
    chk("R10/R8 status after program", 32'(dout), 32'(exp_status(fail_m, 1'b1, wp)));
  endtask

  task automatic do_erase(input logic wp, input logic pass);
    int n;
    wp_n = wp; op_pass = pass;
    put_cmd(8'h60);
    put_addr(8'($urandom));
    put_addr(8'($urandom));
    put_cmd(8'hD0);
    chk("R5/R6 erase_start", 32'(erase_start), 32'(wp));
    if (wp) begin
      busy_len(n);
      chk("R5 erase busy length", 32'(n), 32'(TE));
      fail_m = !pass;
    end else chk("R6 stays ready", 32'(rb_n), 32'd1);
    put_cmd(8'h70);
    chk("R10/R8 status after erase", 32'(dout), 32'(exp_status(fail_m, 1'b1, wp)));
  endtask

  initial begin
    int n;
    logic [7:0] b, held;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 rb_n", 32'(rb_n), 32'd1);
    chk("R1 dout", 32'(dout), 32'h00);
    chk("R1 starts", 32'({prog_start, erase_start, load_start}), 32'd0);

    // R8 / R9
    put_cmd(8'h70);
    chk("R8 status after reset", 32'(dout), 32'hC0);
    strobe(); strobe();
    chk("R9 status held over strobes", 32'(dout), 32'hC0);

    // R2
    put_cmd(8'h33);
    chk("R2 undefined code ignored", 32'(dout), 32'hC0);

    // R11
    put_cmd(8'h90); put_addr(8'h00);
    chk("R11 maker byte", 32'(dout), 32'hEC);
    strobe(); chk("R11 device byte", 32'(dout), 32'(DEV));
    strobe(); chk("R11 tail byte", 32'(dout), 32'hA5);
    strobe(); chk("R11 past end", 32'(dout), 32'h00);
    put_cmd(8'h90); put_addr(8'h01);
    chk("R11 wrong address byte", 32'(dout), 32'h00);

    // R3
    put_cmd(8'h00); put_addr(8'h12); put_addr(8'h34);
    chk("R3 no load before third address", 32'(load_start), 32'd0);
    put_addr(8'h56);
    chk("R3 load_start", 32'(load_start), 32'd1);
    busy_len(n);
    chk("R3 read busy length", 32'(n), 32'(TR));
    chk("R3 data mode reads 00h", 32'(dout), 32'h00);
    put_cmd(8'h50); put_addr(8'h01); put_addr(8'h02); put_cmd(8'h70);
    chk("R3 short read starts nothing", 32'(rb_n), 32'd1);

    // R4, R10
    do_program(1'b1, 1'b1, 2);
    do_program(1'b1, 1'b0, 1);
    do_program(1'b1, 1'b1, 0);
    // R5, R6
    do_erase(1'b1, 1'b1);
    do_erase(1'b0, 1'b0);
    do_program(1'b0, 1'b1, 3);

    // R7: commands while busy
    wp_n = 1; op_pass = 1;
    put_cmd(8'h80); put_addr(1); put_addr(2); put_addr(3); put_data(8'hAA); put_cmd(8'h10);
    chk("R7 setup program started", 32'(prog_start), 32'd1);
    put_cmd(8'h70);
    chk("R7/R8 status while busy", 32'(dout), 32'(exp_status(1'b0, 1'b0, 1'b1)));
    put_cmd(8'h90);
    chk("R7 ident ignored while busy", 32'(dout), 32'(exp_status(1'b0, 1'b0, 1'b1)));
    busy_len(n);
    chk("R7 busy not disturbed", 32'(n), 32'(TP - 4));
    fail_m = 0;
    chk("R7/R9 status after busy", 32'(dout), 32'hC0);

    // R12: reset aborts busy erase, clears fail
    do_program(1'b1, 1'b0, 1);
    op_pass = 0;
    put_cmd(8'h60); put_addr(1); put_addr(2); put_cmd(8'hD0);
    put_cmd(8'hFF);
    chk("R12 busy after abort", 32'(rb_n), 32'd0);
    busy_len(n);
    chk("R12 abort reset busy length", 32'(n), 32'(TRB));
    fail_m = 0;
    put_cmd(8'h70);
    chk("R12 status C0h after reset", 32'(dout), 32'hC0);
    put_cmd(8'hFF);
    busy_len(n);
    chk("R12 idle reset busy length", 32'(n), 32'(TRI));
    put_cmd(8'h80); put_addr(1); put_addr(2); put_addr(3); put_data(8'h5A);
    put_cmd(8'hFF); busy_len(n);
    put_cmd(8'h10);
    chk("R12 reset clears sequence", 32'(prog_start), 32'd0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      case ($urandom % 3)
        0: do_program(1'($urandom % 4 != 0), 1'($urandom), int'($urandom % 3));
        1: do_erase(1'($urandom % 4 != 0), 1'($urandom));
        default: begin
          wp_n = 1'($urandom);
          do b = 8'($urandom); while (is_defined(b));
          put_cmd(8'h70);
          held = dout;
          put_cmd(b);
          chk("R2 random undefined code", 32'(dout), 32'(held));
        end
      endcase
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule